// File: doc/BRIEF.md
# Banked Primary Cache Diagnostic Register Unit

This unit holds the control state and the diagnostic view of a small primary cache that is split into several parallel banks. A four-bit control register sits on a dedicated processor-register port. It sets whether the cache is on and whether diagnostic access is open, it can force inverted parity for tests, and it can trigger a flush of the whole cache. The unit also holds each bank's tag array, line valid bits, data lines and stored parity. The lookup path reads all of this and is not part of this block.

While diagnostic access is open, a memory-mapped window on a simple synchronous register bus reaches three things: the tags, the data lines, and a combined register that holds the bank enables and reports the latest bank hit. A write into the tag or data area goes to every enabled bank in the same cycle. A read returns the entry from the lowest-numbered enabled bank. This lets software initialise every bank at once and then inspect them one at a time by narrowing the enable mask. A fuse input per bank marks banks that are broken. Such a bank stays disabled whatever software writes.

Firmware opens diagnostic access, enables the banks, writes every tag with its valid bit clear, pulses flush, and then closes diagnostic access.

Top module: `cache_diag_regs`

## Requirements
- R1: The control register reads as {bit3 = parity invert, bit2 = cache on, bit1 = 0, bit0 = diagnostic access}. It resets to 0. A write replaces bits 3, 2 and 0. Outputs `cache_on` and `par_inv` follow bits 2 and 3.
- R2: A control write with bit 1 set clears every valid bit in every bank and clears the hit field, both by the next cycle. Bit 1 always reads back as 0.
- R3: With diagnostic access on, a bus write to offsets 0x400–0x7FF stores the word in line `addr[9:2]` of every enabled bank. Disabled banks keep their contents.
- R4: With diagnostic access on, a bus write to offsets 0x000–0x3FF writes tag `addr[9:3]` in every enabled bank. Bit 30 of the word is stored as the valid bit and bits 29:4 as the tag field.
- R5: A diagnostic tag or data read returns the entry of the lowest-numbered enabled bank. It returns 0 when no bank is enabled.
- R6: A tag read returns {bit31 = stored tag parity, bit30 = valid, bits 29:4 = tag, bits 3:0 = stored parity of data line `addr[9:2]`}.
- R7: Parity is even and is generated when the entry is written. The tag parity is the XOR of bits 29:4. Data parity bit i is the XOR of byte i. Every generated parity bit is inverted while control bit 3 is set.
- R8: The bank register answers at 4-byte-aligned offsets 0x800–0xFFFC. It reads {31:16 = 0, 15:8 = hit bits, 7:0 = effective enables}, with bits at or above NBANKS in each field reading 0. A write to it takes effect only when `bus_be` is 4'hF.
- R9: A bank whose `bank_fused` bit is 1 is never enabled. Its enable bit and its `bank_on` bit read 0 whatever was written.
- R10: On `lookup_stb`, the hit field loads the one-hot `lookup_hit` vector. A flush in the same cycle takes priority and clears the field.
- R11: With diagnostic access off, and at misaligned bank-register offsets, window writes have no effect and window reads return 0.
- R12: `bus_rdata` is registered. It updates on the clock edge of a cycle with `bus_re` high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ccr_we | input | 1 | Control register write strobe |
| ccr_wdata | input | 4 | Control register write data |
| ccr_rdata | output | 4 | Control register read value |
| bus_addr | input | 16 | Diagnostic window byte offset |
| bus_wdata | input | 32 | Window write data |
| bus_be | input | 4 | Byte enables; must be 4'hF to write the bank register |
| bus_we | input | 1 | Window write strobe |
| bus_re | input | 1 | Window read strobe |
| bus_rdata | output | 32 | Registered window read data |
| bank_fused | input | NBANKS | 1 marks a permanently broken bank |
| lookup_stb | input | 1 | Lookup path reports a data-stream access |
| lookup_hit | input | NBANKS | One-hot bank that hit on that access |
| cache_on | output | 1 | Cache enable to the lookup path |
| par_inv | output | 1 | Parity inversion to the lookup path |
| bank_on | output | NBANKS | Effective bank enables |

## Verification
The embedded assertions check on every cycle that a flush leaves all valid bits and the hit field clear, and that a tag write lands in the addressed valid bit. They also check that stored enables never include a bank that was fused at write time, that the hit field is at most one-hot, and that read data is zero when diagnostic access is off or no bank is enabled. Read data must also hold between reads. Only the bench scenarios can show the rest. These are the broadcast writes and the priority choice across changing enable masks, the exact tag and parity layout (including inverted parity), the ignored misaligned and partial-width writes, and the ordering when a flush meets a lookup report.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

  localparam int WORD_W   = 32;
  localparam int TFIELD_L = 4;
  localparam int TFIELD_H = 29;
  localparam int TFIELD_W = TFIELD_H - TFIELD_L + 1;
  localparam int VALID_B  = 30;
  localparam int BYTES    = WORD_W / 8;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_TAG  = 2'd1,
    WIN_DATA = 2'd2,
    WIN_BANK = 2'd3
  } win_e;

  function automatic logic tag_par(input logic [TFIELD_W-1:0] t, input logic inv);
    return (^t) ^ inv;
  endfunction

  function automatic logic [BYTES-1:0] byte_par(input logic [WORD_W-1:0] w, input logic inv);
    logic [BYTES-1:0] p;
    for (int i = 0; i < BYTES; i++) p[i] = (^w[i*8 +: 8]) ^ inv;
    return p;
  endfunction

endpackage

// File: rtl/cdr_ctrl.sv
module cdr_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [3:0] wdata,
  output logic [3:0] rdata,
  output logic       diag,
  output logic       cache_on,
  output logic       par_inv,
  output logic       flush
);

  logic [2:0] ctl_q, ctl_d;   // {par_inv, cache_on, diag}

  always_comb begin
    ctl_d = ctl_q;
    if (we) ctl_d = {wdata[3], wdata[2], wdata[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign flush    = we & wdata[1];
  assign par_inv  = ctl_q[2];
  assign cache_on = ctl_q[1];
  assign diag     = ctl_q[0];
  assign rdata    = {ctl_q[2], ctl_q[1], 1'b0, ctl_q[0]};

  // R1: a control write is visible on the read port next cycle
  a_r1_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata == {$past(wdata[3]), $past(wdata[2]), 1'b0, $past(wdata[0])}));

endmodule

// File: rtl/cdr_decode.sv
module cdr_decode
  import cdr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_IDX_W = 8
) (
  input  logic                  diag,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  we,
  input  logic [3:0]            be,
  output win_e                  win,
  output logic                  wr_tag,
  output logic                  wr_data,
  output logic                  wr_bank,
  output logic [LINE_IDX_W-1:0] line_idx,
  output logic [LINE_IDX_W-2:0] tag_idx
);

  localparam int WIN_B = LINE_IDX_W + 2;

  logic [ADDR_W-WIN_B-1:0] top;
  logic                    aligned;

  assign top     = addr[ADDR_W-1:WIN_B];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    win = WIN_NONE;
    if (diag) begin
      if (top == '0)                           win = WIN_TAG;
      else if (top == {{(ADDR_W-WIN_B-1){1'b0}}, 1'b1}) win = WIN_DATA;
      else if (aligned)                        win = WIN_BANK;
    end
  end

  assign wr_tag   = we && (win == WIN_TAG);
  assign wr_data  = we && (win == WIN_DATA);
  assign wr_bank  = we && (win == WIN_BANK) && (be == 4'hF);
  assign line_idx = addr[WIN_B-1:2];
  assign tag_idx  = addr[WIN_B-1:3];

endmodule

// File: rtl/cdr_bank.sv
module cdr_bank
  import cdr_pkg::*;
#(
  parameter int LINE_IDX_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  tag_we,
  input  logic                  data_we,
  input  logic [LINE_IDX_W-1:0] line_idx,
  input  logic [LINE_IDX_W-2:0] tag_idx,
  input  logic [WORD_W-1:0]     wdata,
  input  logic                  par_inv,
  output logic [WORD_W-1:0]     data_rd,
  output logic [WORD_W-1:0]     tag_rd
);

  localparam int LINES = 1 << LINE_IDX_W;
  localparam int TAGS  = LINES / 2;

  logic [WORD_W-1:0]   dmem [LINES];
  logic [BYTES-1:0]    dpar [LINES];
  logic [TFIELD_W-1:0] tmem [TAGS];
  logic                tpar [TAGS];
  logic [TAGS-1:0]     valid_q, valid_d;

  always_ff @(posedge clk) begin
    if (data_we) begin
      dmem[line_idx] <= wdata;
      dpar[line_idx] <= byte_par(wdata, par_inv);
    end
  end

  always_ff @(posedge clk) begin
    if (tag_we) begin
      tmem[tag_idx] <= wdata[TFIELD_H:TFIELD_L];
      tpar[tag_idx] <= tag_par(wdata[TFIELD_H:TFIELD_L], par_inv);
    end
  end

  always_comb begin
    valid_d = valid_q;
    if (flush)       valid_d = '0;
    else if (tag_we) valid_d[tag_idx] = wdata[VALID_B];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  assign data_rd = dmem[line_idx];
  assign tag_rd  = {tpar[tag_idx], valid_q[tag_idx], tmem[tag_idx], dpar[line_idx]};

  // R2: flush leaves every valid bit clear
  a_r2_flush_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  // R4: tag write stores the valid bit at the addressed tag
  a_r4_tag_valid_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_we && !flush) |=> (valid_q[$past(tag_idx)] == $past(wdata[VALID_B])));

endmodule

// File: rtl/cdr_bankreg.sv
module cdr_bankreg #(
  parameter int NBANKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [NBANKS-1:0] wdata,
  input  logic [NBANKS-1:0] fused,
  input  logic              flush,
  input  logic              lookup_stb,
  input  logic [NBANKS-1:0] lookup_hit,
  output logic [NBANKS-1:0] bank_on,
  output logic [NBANKS-1:0] hit
);

  logic [NBANKS-1:0] en_q, en_d, hit_q, hit_d;

  always_comb begin
    en_d = en_q;
    if (we) en_d = wdata & ~fused;
  end

  always_comb begin
    hit_d = hit_q;
    if (flush)           hit_d = '0;
    else if (lookup_stb) hit_d = lookup_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      hit_q <= '0;
    end else begin
      en_q  <= en_d;
      hit_q <= hit_d;
    end
  end

  assign bank_on = en_q & ~fused;
  assign hit     = hit_q;

  // R9: a fused bank never enters the stored enables
  a_r9_fused_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((en_q & $past(fused)) == '0));

  // R10: the hit field names at most one bank
  a_r10_hit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_q));

  // R10: a flush wins over a same-cycle lookup report
  a_r10_flush_clears_hit: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (hit_q == '0));

endmodule

// File: rtl/cache_diag_regs.sv
module cache_diag_regs
  import cdr_pkg::*;
#(
  parameter int NBANKS     = 4,
  parameter int ADDR_W     = 16,
  parameter int LINE_IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ccr_we,
  input  logic [3:0]        ccr_wdata,
  output logic [3:0]        ccr_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [3:0]        bus_be,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [NBANKS-1:0] bank_fused,
  input  logic              lookup_stb,
  input  logic [NBANKS-1:0] lookup_hit,
  output logic              cache_on,
  output logic              par_inv,
  output logic [NBANKS-1:0] bank_on
);

  localparam int HIT_L = 8;

  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  logic                  diag, flush;
  win_e                  win;
  logic                  wr_tag, wr_data, wr_bank;
  logic [LINE_IDX_W-1:0] line_idx;
  logic [LINE_IDX_W-2:0] tag_idx;
  logic [NBANKS-1:0]     hit;

  cdr_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .we       (ccr_we),
    .wdata    (ccr_wdata),
    .rdata    (ccr_rdata),
    .diag     (diag),
    .cache_on (cache_on),
    .par_inv  (par_inv),
    .flush    (flush)
  );

  cdr_decode #(.ADDR_W(ADDR_W), .LINE_IDX_W(LINE_IDX_W)) u_dec (
    .diag     (diag),
    .addr     (bus_addr),
    .we       (bus_we),
    .be       (bus_be),
    .win      (win),
    .wr_tag   (wr_tag),
    .wr_data  (wr_data),
    .wr_bank  (wr_bank),
    .line_idx (line_idx),
    .tag_idx  (tag_idx)
  );

  cdr_bankreg #(.NBANKS(NBANKS)) u_breg (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .we         (wr_bank),
    .wdata      (bus_wdata[NBANKS-1:0]),
    .fused      (bank_fused),
    .flush      (flush),
    .lookup_stb (lookup_stb),
    .lookup_hit (lookup_hit),
    .bank_on    (bank_on),
    .hit        (hit)
  );

  logic [WORD_W-1:0] bk_data [NBANKS];
  logic [WORD_W-1:0] bk_tag  [NBANKS];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    cdr_bank #(.LINE_IDX_W(LINE_IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .flush    (flush),
      .tag_we   (wr_tag & bank_on[b]),
      .data_we  (wr_data & bank_on[b]),
      .line_idx (line_idx),
      .tag_idx  (tag_idx),
      .wdata    (bus_wdata),
      .par_inv  (par_inv),
      .data_rd  (bk_data[b]),
      .tag_rd   (bk_tag[b])
    );
  end

  // priority pick: lowest-numbered enabled bank wins
  logic [WORD_W-1:0] pick_data, pick_tag;
  always_comb begin
    pick_data = '0;
    pick_tag  = '0;
    for (int i = NBANKS - 1; i >= 0; i--) begin
      if (bank_on[i]) begin
        pick_data = bk_data[i];
        pick_tag  = bk_tag[i];
      end
    end
  end

  logic [WORD_W-1:0] breg_word;
  always_comb begin
    breg_word = '0;
    breg_word[NBANKS-1:0]           = bank_on;
    breg_word[HIT_L +: NBANKS]      = hit;
  end

  logic [WORD_W-1:0] rd_val, rdata_q, rdata_d;
  always_comb begin
    unique case (win)
      WIN_TAG:  rd_val = pick_tag;
      WIN_DATA: rd_val = pick_data;
      WIN_BANK: rd_val = breg_word;
      default:  rd_val = '0;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_re) rdata_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end
  assign bus_rdata = rdata_q;

  // R11: window reads with diagnostic access off return zero
  a_r11_closed_reads_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_re && !diag) |=> (bus_rdata == '0));

  // R5: tag or data read with no enabled bank returns zero
  a_r5_no_bank_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_re && (win == WIN_DATA || win == WIN_TAG) && bank_on == '0) |=> (bus_rdata == '0));

  // R12: read data holds between reads
  a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_i_n)
    !bus_re |=> $stable(bus_rdata));

endmodule

// File: tb/sim_cache_diag_regs.sv
`timescale 1ns/1ps
module sim_cache_diag_regs;

  localparam int NB = 4;
  localparam int N  = 47;
  localparam logic [1:0] CW = 2'd0, CR = 2'd1, BW = 2'd2, BR = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ccr_we;
  logic [3:0]  ccr_wdata, ccr_rdata;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  bus_be;
  logic        bus_we, bus_re;
  logic [NB-1:0] bank_fused, lookup_hit, bank_on;
  logic        lookup_stb, cache_on, par_inv;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cache_diag_regs #(.NBANKS(NB)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ccr_we(ccr_we), .ccr_wdata(ccr_wdata), .ccr_rdata(ccr_rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bank_fused(bank_fused), .lookup_stb(lookup_stb), .lookup_hit(lookup_hit),
    .cache_on(cache_on), .par_inv(par_inv), .bank_on(bank_on)
  );

  // {req, op, be, addr, wdata, exp}
  function automatic logic [89:0] V(input logic [3:0] r, input logic [1:0] op,
      input logic [3:0] be, input logic [15:0] a, input logic [31:0] wd, input logic [31:0] ex);
    return {r, op, be, a, wd, ex};
  endfunction

  localparam logic [89:0] TBL [N] = '{
    V(1, CW, 4'hF, 16'h0000, 32'h1, 32'h0),
    V(1, CR, 4'hF, 16'h0000, 32'h0, 32'h1),          // R1 diag bit reads back
    V(8, BW, 4'hF, 16'h0800, 32'hFF, 32'h0),
    V(8, BR, 4'hF, 16'h0800, 32'h0, 32'hB),          // R8/R9 bank 2 fused
    V(8, BR, 4'hF, 16'hFFFC, 32'h0, 32'hB),          // R8 top of range
    V(3, BW, 4'hF, 16'h0400, 32'h12345678, 32'h0),
    V(3, BR, 4'hF, 16'h0400, 32'h0, 32'h12345678),   // R3
    V(3, BW, 4'hF, 16'h0404, 32'hFF, 32'h0),
    V(4, BW, 4'hF, 16'h0000, 32'h40000AB0, 32'h0),
    V(4, BR, 4'hF, 16'h0000, 32'h0, 32'hC0000AB4),   // R4 R6 R7 parity layout
    V(6, BR, 4'hF, 16'h0004, 32'h0, 32'hC0000AB0),   // R6 data parity of line 1
    V(3, BW, 4'hF, 16'h0408, 32'h11111111, 32'h0),
    V(3, BW, 4'hF, 16'h0800, 32'h0A, 32'h0),
    V(3, BW, 4'hF, 16'h0408, 32'h22222222, 32'h0),
    V(3, BW, 4'hF, 16'h0800, 32'h02, 32'h0),
    V(3, BW, 4'hF, 16'h0408, 32'h33333333, 32'h0),
    V(3, BW, 4'hF, 16'h0800, 32'h08, 32'h0),
    V(3, BR, 4'hF, 16'h0408, 32'h0, 32'h22222222),   // R3 bank 3 untouched by last write
    V(3, BW, 4'hF, 16'h0800, 32'h02, 32'h0),
    V(3, BR, 4'hF, 16'h0408, 32'h0, 32'h33333333),   // R3
    V(5, BW, 4'hF, 16'h0800, 32'h0B, 32'h0),
    V(5, BR, 4'hF, 16'h0408, 32'h0, 32'h11111111),   // R5 bank 0 wins
    V(5, BW, 4'hF, 16'h0800, 32'h00, 32'h0),
    V(5, BR, 4'hF, 16'h0408, 32'h0, 32'h0),          // R5 none enabled
    V(5, BW, 4'hF, 16'h0800, 32'h0B, 32'h0),
    V(7, CW, 4'hF, 16'h0000, 32'h9, 32'h0),
    V(7, BW, 4'hF, 16'h040C, 32'h0, 32'h0),
    V(7, BW, 4'hF, 16'h0008, 32'h0, 32'h0),
    V(7, BR, 4'hF, 16'h000C, 32'h0, 32'h8000000F),   // R7 inverted parity
    V(1, CR, 4'hF, 16'h0000, 32'h0, 32'h9),          // R1
    V(1, CW, 4'hF, 16'h0000, 32'h5, 32'h0),
    V(1, CR, 4'hF, 16'h0000, 32'h0, 32'h5),          // R1
    V(2, CW, 4'hF, 16'h0000, 32'h3, 32'h0),
    V(2, CR, 4'hF, 16'h0000, 32'h0, 32'h1),          // R2 flush bit reads 0
    V(2, BR, 4'hF, 16'h0000, 32'h0, 32'h80000AB4),   // R2 valid cleared
    V(11, CW, 4'hF, 16'h0000, 32'h0, 32'h0),
    V(11, BW, 4'hF, 16'h0800, 32'h0, 32'h0),
    V(11, BR, 4'hF, 16'h0800, 32'h0, 32'h0),         // R11
    V(11, BW, 4'hF, 16'h0400, 32'hDEADBEEF, 32'h0),
    V(11, BR, 4'hF, 16'h0400, 32'h0, 32'h0),         // R11
    V(11, CW, 4'hF, 16'h0000, 32'h1, 32'h0),
    V(11, BR, 4'hF, 16'h0800, 32'h0, 32'hB),         // R11 write was ignored
    V(11, BR, 4'hF, 16'h0400, 32'h0, 32'h12345678),  // R11
    V(11, BW, 4'hF, 16'h0802, 32'h0, 32'h0),
    V(8, BW, 4'h3, 16'h0800, 32'h0, 32'h0),
    V(8, BR, 4'hF, 16'h0800, 32'h0, 32'hB),          // R8 partial write ignored
    V(11, BR, 4'hF, 16'h0802, 32'h0, 32'h0)          // R11 misaligned read
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    ccr_we = 0; bus_we = 0; bus_re = 0; lookup_stb = 0; bus_be = 4'hF;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1;
    @(negedge clk); idle(); d = bus_rdata;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] w);
    @(negedge clk); bus_addr = a; bus_wdata = w; bus_we = 1;
    @(negedge clk); idle();
  endtask

  task automatic ccr_write(input logic [3:0] w);
    @(negedge clk); ccr_wdata = w; ccr_we = 1;
    @(negedge clk); idle();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 0; idle(); ccr_wdata = 0; bus_addr = 0; bus_wdata = 0;
    bank_fused = 4'b0100; lookup_hit = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // reset state: R1
    check("R1 reset ccr", {28'b0, ccr_rdata}, 32'h0);
    check("R12 reset rdata", bus_rdata, 32'h0);
    check("R9 reset bank_on", {28'b0, bank_on}, 32'h0);

    for (int i = 0; i < N; i++) begin
      logic [89:0] e;
      e = TBL[i];
      @(negedge clk);
      bus_addr = e[79:64]; bus_wdata = e[63:32]; bus_be = e[83:80];
      ccr_wdata = e[35:32];
      case (e[85:84])
        CW: ccr_we = 1;
        BW: bus_we = 1;
        BR: bus_re = 1;
        default: ;
      endcase
      @(negedge clk);
      idle();
      if (e[85:84] == BR) begin
        checks++;
        if (bus_rdata !== e[31:0]) begin
          fails++;
          $display("FAIL R%0d entry %0d: got %h expected %h", e[89:86], i, bus_rdata, e[31:0]);
        end
      end else if (e[85:84] == CR) begin
        checks++;
        if ({28'b0, ccr_rdata} !== e[31:0]) begin
          fails++;
          $display("FAIL R%0d entry %0d: got %h expected %h", e[89:86], i, ccr_rdata, e[31:0]);
        end
      end
    end

    // R1 outputs follow control bits
    ccr_write(4'hD);
    check("R1 cache_on/par_inv", {30'b0, par_inv, cache_on}, 32'h3);
    ccr_write(4'h1);

    // R10 lookup report lands in hit field
    @(negedge clk); lookup_stb = 1; lookup_hit = 4'b0010;
    @(negedge clk); idle();
    bus_read(16'h0800, d);
    check("R10 hit field", d, 32'h0000020B);

    // R12 rdata holds while other traffic runs
    bus_write(16'h0400, 32'h0BADF00D);
    check("R12 hold", bus_rdata, 32'h0000020B);

    // R10 flush beats same-cycle lookup
    @(negedge clk); lookup_stb = 1; lookup_hit = 4'b1000; ccr_wdata = 4'h3; ccr_we = 1;
    @(negedge clk); idle();
    bus_read(16'h0800, d);
    check("R10 flush priority", d, 32'h0000000B);

    // R9 fuse changes mask enables
    @(negedge clk); bank_fused = 4'b0001;
    @(negedge clk);
    check("R9 bank_on fused", {28'b0, bank_on}, 32'hA);
    bus_write(16'h0800, 32'h0F);
    bus_read(16'h0800, d);
    check("R9 write under fuse", d, 32'hE);
    @(negedge clk); bank_fused = 4'b0100;
    @(negedge clk);
    check("R9 stored then masked", {28'b0, bank_on}, 32'hA);

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    #1;
    check("R1 async reset ccr", {28'b0, ccr_rdata}, 32'h0);
    check("R9 async reset enables", {28'b0, bank_on}, 32'h0);
    repeat (2) @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    ccr_write(4'h1);
    bus_read(16'h0800, d);
    check("R8 bank reg after reset", d, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule